// File: doc/BRIEF.md
# Eight-Operation Function Register

This block is a small state register whose next value is chosen, once per rising clock edge, from eight candidate words by a 3-bit operation code. The candidates cover logical shifts in both directions (each with its own fill bit), rotates in both directions, holding the current word, loading a parallel word, inverting every bit, and forcing every bit to one. A synchronous active-high reset clears the word and wins over any operation code.

The word is presented on `out_word`, most significant bit first (bit W-1 is the leftmost position, bit 0 the rightmost). "Left" means toward bit W-1 and "right" means toward bit 0. The operation code, the fill bits and the parallel word are sampled only at the clock edge, so a controller may change them freely between edges. The default width is 4.

Top module: `func_reg`

## Requirements
- R1: When `rst` is high at a rising edge, `out_word` becomes all zeros after that edge, whatever `op_sel` holds.
- R2: Code 3'b000 shifts left: each bit moves one place toward bit W-1, the old bit W-1 is dropped and bit 0 takes `fill_lo`.
- R3: Code 3'b001 rotates left: the old bit W-1 re-enters at bit 0; `fill_lo` and `fill_hi` have no effect.
- R4: Code 3'b010 shifts right: each bit moves one place toward bit 0, the old bit 0 is dropped and bit W-1 takes `fill_hi`.
- R5: Code 3'b011 rotates right: the old bit 0 re-enters at bit W-1; `fill_lo` and `fill_hi` have no effect.
- R6: Code 3'b100 holds the word unchanged.
- R7: Code 3'b101 loads `load_word` with bit-for-bit mapping (bit k of `load_word` goes to bit k of `out_word`, so the leftmost input lands in the leftmost position).
- R8: Code 3'b110 replaces the word with its bitwise complement.
- R9: Code 3'b111 sets every bit of the word to one.
- R10: Exactly one operation takes effect per rising edge, and its result is visible on `out_word` directly after that edge; changes of `op_sel`, `fill_lo`, `fill_hi` or `load_word` between edges leave `out_word` unchanged.
- R11: With `load_word` = 0011, `fill_lo` = 1, `fill_hi` = 0 and a start word of 0101, the codes 000, 001, 010, 100, 011, 101, 111, 000, 110 applied on successive edges give 1011, 0111, 0011, 0011, 1001, 0011, 1111, 1111, 0000.
- R12: A left shift of 1111 with `fill_lo` = 1 leaves 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| op_sel | input | 3 | Operation code, sampled at the edge |
| load_word | input | W | Parallel word used by the load operation |
| fill_lo | input | 1 | Bit entering position 0 on a left shift |
| fill_hi | input | 1 | Bit entering position W-1 on a right shift |
| out_word | output | W | Current register word |

## Verification
Every result, including reset, is due one edge after the inputs that select it: the value sampled at an edge appears on `out_word` right after that edge and stays until the next one. The driver sets inputs at the falling edge and queues the word a bench-side model predicts; the monitor takes one queued word a short delay after each rising edge, so each comparison lands in the cycle its operation completes. Between edges the driver also scrambles the inputs and confirms that `out_word` has not moved, before putting the real stimulus in place.

// File: rtl/func_reg_pkg.sv
package func_reg_pkg;

  localparam int OP_BITS  = 3;
  localparam int OP_COUNT = 1 << OP_BITS;

  // Operation codes; the numeric values are the external encoding of op_sel.
  typedef enum logic [OP_BITS-1:0] {
    OP_SHL  = 3'b000,
    OP_ROL  = 3'b001,
    OP_SHR  = 3'b010,
    OP_ROR  = 3'b011,
    OP_HOLD = 3'b100,
    OP_LOAD = 3'b101,
    OP_INV  = 3'b110,
    OP_ONES = 3'b111
  } op_e;

endpackage

// File: rtl/func_reg_decode.sv
module func_reg_decode
  import func_reg_pkg::*;
(
  input  logic [OP_BITS-1:0]  op_sel,
  output logic [OP_COUNT-1:0] op_onehot
);

  // One select line per operation code.
  for (genvar o = 0; o < OP_COUNT; o++) begin : g_dec
    assign op_onehot[o] = (op_sel == OP_BITS'(o));
  end

endmodule

// File: rtl/func_reg_candidates.sv
module func_reg_candidates
  import func_reg_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]                cur_word,
  input  logic [W-1:0]                load_word,
  input  logic                        fill_lo,
  input  logic                        fill_hi,
  output logic [OP_COUNT-1:0][W-1:0]  cand_words
);

  localparam int TOP = W - 1;

  function automatic logic [W-1:0] f_shift_left(input logic [W-1:0] v, input logic fin);
    return {v[TOP-1:0], fin};
  endfunction

  function automatic logic [W-1:0] f_shift_right(input logic [W-1:0] v, input logic fin);
    return {fin, v[TOP:1]};
  endfunction

  function automatic logic [W-1:0] f_rotate_left(input logic [W-1:0] v);
    return f_shift_left(v, v[TOP]);
  endfunction

  function automatic logic [W-1:0] f_rotate_right(input logic [W-1:0] v);
    return f_shift_right(v, v[0]);
  endfunction

  // Named candidate wires, one per operation.
  logic [W-1:0] shl_word, rol_word, shr_word, ror_word;
  logic [W-1:0] hold_word, load_cand, inv_word, ones_word;

  assign shl_word  = f_shift_left(cur_word, fill_lo);
  assign rol_word  = f_rotate_left(cur_word);
  assign shr_word  = f_shift_right(cur_word, fill_hi);
  assign ror_word  = f_rotate_right(cur_word);
  assign hold_word = cur_word;
  assign load_cand = load_word;
  assign inv_word  = ~cur_word;
  assign ones_word = '1;

  assign cand_words[int'(OP_SHL)]  = shl_word;
  assign cand_words[int'(OP_ROL)]  = rol_word;
  assign cand_words[int'(OP_SHR)]  = shr_word;
  assign cand_words[int'(OP_ROR)]  = ror_word;
  assign cand_words[int'(OP_HOLD)] = hold_word;
  assign cand_words[int'(OP_LOAD)] = load_cand;
  assign cand_words[int'(OP_INV)]  = inv_word;
  assign cand_words[int'(OP_ONES)] = ones_word;

endmodule

// File: rtl/func_reg_select.sv
module func_reg_select
  import func_reg_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [OP_COUNT-1:0][W-1:0] cand_words,
  input  logic [OP_COUNT-1:0]        op_onehot,
  output logic [W-1:0]               next_word
);

  // AND-OR selection per bit: one gate level of depth regardless of code.
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [OP_COUNT-1:0] column;
    for (genvar o = 0; o < OP_COUNT; o++) begin : g_op
      assign column[o] = cand_words[o][b];
    end
    assign next_word[b] = |(column & op_onehot);
  end

endmodule

// File: rtl/func_reg.sv
module func_reg
  import func_reg_pkg::*;
#(
  parameter int W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_BITS-1:0]  op_sel,
  input  logic [W-1:0]        load_word,
  input  logic                fill_lo,
  input  logic                fill_hi,
  output logic [W-1:0]        out_word
);

  localparam int TOP = W - 1;

  logic [OP_COUNT-1:0]        op_onehot;
  logic [OP_COUNT-1:0][W-1:0] cand_words;
  logic [W-1:0]               next_word;
  logic [W-1:0]               state_q;

  func_reg_decode u_decode (
    .op_sel    (op_sel),
    .op_onehot (op_onehot)
  );

  func_reg_candidates #(.W(W)) u_cand (
    .cur_word   (state_q),
    .load_word  (load_word),
    .fill_lo    (fill_lo),
    .fill_hi    (fill_hi),
    .cand_words (cand_words)
  );

  func_reg_select #(.W(W)) u_sel (
    .cand_words (cand_words),
    .op_onehot  (op_onehot),
    .next_word  (next_word)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= next_word;
  end

  assign out_word = state_q;

  // Assertions next to the state they guard.
  assert_reset_R1: assert property (@(posedge clk) rst |=> (state_q == '0));

  assert_one_op_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(op_onehot) == 1);

  assert_shl_R2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SHL) |=> (state_q[0] == $past(fill_lo)) &&
                           (state_q[TOP:1] == $past(state_q[TOP-1:0])));

  assert_rol_R3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ROL) |=> (state_q[0] == $past(state_q[TOP])) &&
                           (state_q[TOP:1] == $past(state_q[TOP-1:0])));

  assert_shr_R4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SHR) |=> (state_q[TOP] == $past(fill_hi)) &&
                           (state_q[TOP-1:0] == $past(state_q[TOP:1])));

  assert_ror_R5: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ROR) |=> (state_q[TOP] == $past(state_q[0])) &&
                           (state_q[TOP-1:0] == $past(state_q[TOP:1])));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_HOLD) |=> $stable(state_q));

  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_LOAD) |=> (state_q == $past(load_word)));

  assert_inv_R8: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_INV) |=> ((state_q ^ $past(state_q)) == {W{1'b1}}));

  assert_ones_R9: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ONES) |=> (&state_q));

endmodule

// File: tb/func_reg_tb.sv
module func_reg_tb;

  localparam int W = 4;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op_sel = 3'b100;
  logic [W-1:0] load_word = '0;
  logic         fill_lo = 1'b0;
  logic         fill_hi = 1'b0;
  logic [W-1:0] out_word;

  int n_vec  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;
  item_t exp_q[$];
  logic [W-1:0] model;

  always #2.5 clk = ~clk;   // 200 MHz

  func_reg #(.W(W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .op_sel    (op_sel),
    .load_word (load_word),
    .fill_lo   (fill_lo),
    .fill_hi   (fill_hi),
    .out_word  (out_word)
  );

  // Bench-side reference, written bit by bit.
  function automatic logic [W-1:0] ref_next(input logic [2:0] op, input logic [W-1:0] v,
                                            input logic [W-1:0] ld, input logic fl, input logic fh);
    logic [W-1:0] r;
    r = v;
    case (op)
      3'b000: begin for (int i = W-1; i > 0; i--) r[i] = v[i-1]; r[0] = fl; end
      3'b001: begin for (int i = W-1; i > 0; i--) r[i] = v[i-1]; r[0] = v[W-1]; end
      3'b010: begin for (int i = 0; i < W-1; i++) r[i] = v[i+1]; r[W-1] = fh; end
      3'b011: begin for (int i = 0; i < W-1; i++) r[i] = v[i+1]; r[W-1] = v[0]; end
      3'b100: r = v;
      3'b101: r = ld;
      3'b110: for (int i = 0; i < W; i++) r[i] = !v[i];
      default: for (int i = 0; i < W; i++) r[i] = 1'b1;
    endcase
    return r;
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010: return "R4";
      3'b011: return "R5";
      3'b100: return "R6";
      3'b101: return "R7";
      3'b110: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Driver: scramble inputs between edges (R10), then drive and queue expectation.
  task automatic step(input logic r, input logic [2:0] op, input logic [W-1:0] ld,
                      input logic fl, input logic fh, input string tag, input bit use_fixed,
                      input logic [W-1:0] fixed);
    item_t it;
    @(negedge clk);
    if (!$isunknown(model)) begin
      op_sel = ~op; load_word = ~ld; fill_lo = ~fl; fill_hi = ~fh;
      #0.5;
      n_vec++;
      if (out_word !== model) begin
        n_bad++;
        $display("FAIL R10: output moved between edges, got %b expected %b", out_word, model);
      end
    end
    rst = r; op_sel = op; load_word = ld; fill_lo = fl; fill_hi = fh;
    if (r) it.exp = '0;
    else if (use_fixed) it.exp = fixed;
    else it.exp = ref_next(op, model, ld, fl, fh);
    it.tag = r ? "R1" : tag;
    model = it.exp;
    exp_q.push_back(it);
  endtask

  // Monitor: one result is due right after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        n_vec++;
        if (out_word !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b", it.tag, out_word, it.exp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] seq_ops [9];
    logic [W-1:0] seq_exp [9];
    model = 'x;
    // R1: reset, including reset against set-all-ones code
    step(1'b1, 3'b111, '0, 1'b0, 1'b0, "R1", 1'b0, '0);
    step(1'b1, 3'b111, '0, 1'b1, 1'b1, "R1", 1'b0, '0);
    step(1'b0, 3'b111, '0, 1'b0, 1'b0, "R9", 1'b0, '0);
    step(1'b1, 3'b111, 4'b1010, 1'b1, 1'b1, "R1", 1'b0, '0);

    // R11: fixed sequence from start word 0101
    step(1'b0, 3'b101, 4'b0101, 1'b1, 1'b0, "R7", 1'b0, '0);
    seq_ops = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b011, 3'b101, 3'b111, 3'b000, 3'b110};
    seq_exp = '{4'b1011, 4'b0111, 4'b0011, 4'b0011, 4'b1001, 4'b0011, 4'b1111, 4'b1111, 4'b0000};
    for (int k = 0; k < 9; k++)
      step(1'b0, seq_ops[k], 4'b0011, 1'b1, 1'b0, "R11", 1'b1, seq_exp[k]);

    // R12: left shift of 1111 with fill 1
    step(1'b0, 3'b111, '0, 1'b0, 1'b0, "R9", 1'b0, '0);
    step(1'b0, 3'b000, 4'b0000, 1'b1, 1'b0, "R12", 1'b1, 4'b1111);

    // Every operation from every start word with every fill combination
    for (int v = 0; v < (1 << W); v++) begin
      for (int op = 0; op < 8; op++) begin
        for (int f = 0; f < 4; f++) begin
          step(1'b0, 3'b101, W'(v), 1'b0, 1'b0, "R7", 1'b0, '0);
          step(1'b0, 3'(op), W'(v ^ 4'b0110), f[0], f[1], op_tag(3'(op)), 1'b0, '0);
        end
      end
    end

    // Back-to-back operations without reloading (R10 one per edge)
    for (int k = 0; k < 40; k++)
      step(1'b0, 3'(k * 5 + 1), W'(k * 3), k[0], k[1], "R10", 1'b0, '0);

    // Reset in the middle of activity
    step(1'b1, 3'b101, 4'b1111, 1'b1, 1'b1, "R1", 1'b0, '0);
    step(1'b0, 3'b100, 4'b1111, 1'b1, 1'b1, "R6", 1'b0, '0);

    @(negedge clk);
    op_sel = 3'b100;
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule